// File: doc/BRIEF.md
# Single-Transfer DMA Address Engine

This block is the transfer engine that sits behind a DMA controller's register interface. It holds, for each of up to four channels, a 16-bit current address, a 16-bit transfer count, a transfer direction, an 8-bit page value, a mask bit and a terminal-count status bit. When a device raises its request line and its channel is unmasked, the engine grants the channel for one cycle. In that cycle it drives one byte transfer: a 24-bit memory address made from the page value above the current address, and either a memory read or a memory write strobe.

On the cycle after the transfer the channel's address steps up by one and its count steps down by one. The count is programmed as the number of bytes minus one. When a transfer is made with the count at zero, the count rolls over and the channel reaches terminal count. At that point the engine pulses a terminal-count output, sets the channel's status bit and masks the channel. The page value never steps, so the address wraps inside one 64 KB window. Host software loads the page values through byte-wide port writes. It loads the address, count and direction through a per-channel programming strobe, and it sets or clears mask bits one channel at a time.

Top module: `dma_xfer_engine`

## Requirements
- R1: While reset is held and after it is released, `dack`, `mem_rd`, `mem_wr` and `tc` are 0, every bit of `mask_state` is 1 (masked) and every bit of `tc_status` is 0.
- R2: During a grant, `mem_addr[23:16]` is the granted channel's page value and `mem_addr[15:0]` is its current address. A page write with `page_port` 0x87 loads channel 0, 0x83 loads channel 1, 0x81 loads channel 2 and 0x82 loads channel 3. A page write to any other port value changes no page.
- R3: A channel whose `mask_state` bit is 1 is never granted, whatever its request line does.
- R4: A grant raises exactly one `dack` bit, for exactly one cycle, and only for a channel that requested in the cycle before. At least one cycle without a grant separates two grants.
- R5: During a grant, exactly one strobe is high. `mem_rd` is high when the channel was programmed with `prog_dir`=1 (memory read toward the device), and `mem_wr` is high when `prog_dir`=0 (memory write from the device). With no grant, both strobes are low.
- R6: After each transfer, the channel's next grant presents the address plus one, modulo 2^16. Stepping from 0xFFFF gives 0x0000 with the page unchanged.
- R7: A programmed count of C gives exactly C+1 transfers while the request stays high. After those transfers the channel stops.
- R8: On the transfer made with count 0, `tc` is high for one cycle, in the cycle right after that grant. From that cycle on, the channel's `tc_status` bit and `mask_state` bit are 1.
- R9: When several unmasked channels request together, the lowest-numbered channel is granted first.
- R10: A programming strobe for a channel (`prog_we`=1, `prog_chan`) clears that channel's `tc_status` bit and does not change its mask bit. A mask write (`mask_we`, `mask_chan`) sets the mask bit when `mask_set`=1 and clears it when `mask_set`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dreq | input | 4 | Device request, one per channel |
| dack | output | 4 | One-cycle grant, one per channel |
| mem_addr | output | 24 | Memory address, page above current address |
| mem_rd | output | 1 | Memory read strobe during a grant |
| mem_wr | output | 1 | Memory write strobe during a grant |
| tc | output | 1 | Terminal-count pulse |
| mask_state | output | 4 | Mask bit of each channel |
| tc_status | output | 4 | Sticky terminal-count flag of each channel |
| page_we | input | 1 | Page register write strobe |
| page_port | input | 8 | Host port number of the page write |
| page_data | input | 8 | Page value to write |
| prog_we | input | 1 | Channel programming strobe |
| prog_chan | input | 2 | Channel being programmed |
| prog_addr | input | 16 | Start address |
| prog_count | input | 16 | Byte count minus one |
| prog_dir | input | 1 | 1 = memory read, 0 = memory write |
| mask_we | input | 1 | Single-channel mask write strobe |
| mask_chan | input | 2 | Channel whose mask bit is written |
| mask_set | input | 1 | 1 = mask, 0 = unmask |

## Verification
The hardest case to reach is a buffer that starts just below a 64 KB line, so that the address wrap and terminal count fall in the same run. That run also has to show the page staying fixed while the low half passes through zero. The stimulus table programs channels at start addresses 0xFFFE and 0xFFFF with counts long enough to cross the line. It holds the request high and predicts each granted address, and it also predicts the cycle of the terminal-count pulse. Directed runs then cover a masked request, contention between two channels, and page writes to ports that do not decode.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_XFER = 1'b1
   } xfer_state_e;

   // Host port that loads the page value of a channel.
   function automatic logic [7:0] page_port_of(input int ch);
      case (ch)
         0:       page_port_of = 8'h87;
         1:       page_port_of = 8'h83;
         2:       page_port_of = 8'h81;
         default: page_port_of = 8'h82;
      endcase
   endfunction

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
   parameter int ADDR_W = 16,
   parameter int PAGE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prog_we,
   input  logic [ADDR_W-1:0] prog_addr,
   input  logic [ADDR_W-1:0] prog_count,
   input  logic              prog_dir,
   input  logic              page_we,
   input  logic [PAGE_W-1:0] page_data,
   input  logic              mask_we,
   input  logic              mask_set,
   input  logic              adv,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [PAGE_W-1:0] page,
   output logic              dir,
   output logic              masked,
   output logic              status,
   output logic              last
);

   logic [ADDR_W-1:0] count_q;

   assign last = (count_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_addr <= '0;
         count_q  <= '0;
         page     <= '0;
         dir      <= 1'b0;
         masked   <= 1'b1;
         status   <= 1'b0;
      end else begin
         if (page_we) page <= page_data;
         if (prog_we) begin
            cur_addr <= prog_addr;
            count_q  <= prog_count;
            dir      <= prog_dir;
            status   <= 1'b0;
         end else if (adv) begin
            cur_addr <= cur_addr + 1'b1;
            count_q  <= count_q - 1'b1;
            if (last) status <= 1'b1;
         end
         if (adv && last)  masked <= 1'b1;
         else if (mask_we) masked <= mask_set;
      end
   end

endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
   parameter int N = 4
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt,
   output logic         any
);

   always_comb begin
      gnt = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            gnt    = '0;
            gnt[i] = 1'b1;
         end
      end
   end

   assign any = |req;

endmodule

// File: rtl/dma_onehot_mux.sv
module dma_onehot_mux #(
   parameter int N = 4,
   parameter int W = 8
) (
   input  logic [N-1:0]   sel,
   input  logic [N*W-1:0] din,
   output logic [W-1:0]   dout
);

   always_comb begin
      dout = '0;
      for (int i = 0; i < N; i++) begin
         if (sel[i]) dout = dout | din[i*W +: W];
      end
   end

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine #(
   parameter int NUM_CH = 4,
   parameter int ADDR_W = 16,
   parameter int PAGE_W = 8,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int MA_W  = PAGE_W + ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] dreq,
   output logic [NUM_CH-1:0] dack,
   output logic [MA_W-1:0]   mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic              tc,
   output logic [NUM_CH-1:0] mask_state,
   output logic [NUM_CH-1:0] tc_status,
   input  logic              page_we,
   input  logic [7:0]        page_port,
   input  logic [PAGE_W-1:0] page_data,
   input  logic              prog_we,
   input  logic [CH_W-1:0]   prog_chan,
   input  logic [ADDR_W-1:0] prog_addr,
   input  logic [ADDR_W-1:0] prog_count,
   input  logic              prog_dir,
   input  logic              mask_we,
   input  logic [CH_W-1:0]   mask_chan,
   input  logic              mask_set
);

   import dma_xfer_pkg::*;

   if (NUM_CH < 1 || NUM_CH > 4) begin : g_bad_num_ch
      $error("dma_xfer_engine: NUM_CH must lie in 1..4");
   end
   if (ADDR_W < 2) begin : g_bad_addr_w
      $error("dma_xfer_engine: ADDR_W must be at least 2");
   end
   if (PAGE_W < 1 || PAGE_W > 8) begin : g_bad_page_w
      $error("dma_xfer_engine: PAGE_W must lie in 1..8");
   end

   xfer_state_e         state_q;
   logic [NUM_CH-1:0]   sel_q;
   logic                tc_q;
   logic [NUM_CH-1:0]   req_eff;
   logic [NUM_CH-1:0]   gnt;
   logic                gnt_any;
   logic [NUM_CH-1:0]   last_vec;
   logic [NUM_CH-1:0]   dir_vec;
   logic [NUM_CH*MA_W-1:0] addr_flat;
   logic [0:0]          dir_sel;
   logic                in_xfer;

   assign in_xfer = (state_q == ST_XFER);
   assign dack    = in_xfer ? sel_q : '0;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic [ADDR_W-1:0] cur_addr;
      logic [PAGE_W-1:0] page;
      logic              ch_prog_we;
      logic              ch_mask_we;
      logic              ch_page_we;

      assign ch_prog_we = prog_we && (prog_chan == CH_W'(i));
      assign ch_mask_we = mask_we && (mask_chan == CH_W'(i));
      assign ch_page_we = page_we && (page_port == page_port_of(i));

      dma_chan_regs #(
         .ADDR_W (ADDR_W),
         .PAGE_W (PAGE_W)
      ) u_regs (
         .clk        (clk),
         .rst_n      (rst_n),
         .prog_we    (ch_prog_we),
         .prog_addr  (prog_addr),
         .prog_count (prog_count),
         .prog_dir   (prog_dir),
         .page_we    (ch_page_we),
         .page_data  (page_data),
         .mask_we    (ch_mask_we),
         .mask_set   (mask_set),
         .adv        (dack[i]),
         .cur_addr   (cur_addr),
         .page       (page),
         .dir        (dir_vec[i]),
         .masked     (mask_state[i]),
         .status     (tc_status[i]),
         .last       (last_vec[i])
      );

      assign addr_flat[i*MA_W +: MA_W] = {page, cur_addr};
   end

   assign req_eff = dreq & ~mask_state;

   dma_prio_arb #(.N(NUM_CH)) u_arb (
      .req (req_eff),
      .gnt (gnt),
      .any (gnt_any)
   );

   dma_onehot_mux #(.N(NUM_CH), .W(MA_W)) u_addr_mux (
      .sel  (sel_q),
      .din  (addr_flat),
      .dout (mem_addr)
   );

   dma_onehot_mux #(.N(NUM_CH), .W(1)) u_dir_mux (
      .sel  (sel_q),
      .din  (dir_vec),
      .dout (dir_sel)
   );

   assign mem_rd = in_xfer &&  dir_sel[0];
   assign mem_wr = in_xfer && !dir_sel[0];
   assign tc     = tc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         sel_q   <= '0;
         tc_q    <= 1'b0;
      end else begin
         tc_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (gnt_any) begin
                  state_q <= ST_XFER;
                  sel_q   <= gnt;
               end
            end
            default: begin
               state_q <= ST_IDLE;
               tc_q    <= |(sel_q & last_vec);
            end
         endcase
      end
   end

endmodule

// File: rtl/dma_xfer_engine_chk.sv
module dma_xfer_engine_chk #(
   parameter int NUM_CH = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CH-1:0] dreq,
   input logic [NUM_CH-1:0] dack,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic              tc,
   input logic [NUM_CH-1:0] mask_state,
   input logic [NUM_CH-1:0] tc_status
);

   assert_dack_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dack));

   assert_grant_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (|dack) |=> (dack == '0));

   assert_grant_needs_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (|dack) |-> ((dack & $past(dreq)) != '0));

   assert_masked_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|dack) |-> ((dack & $past(mask_state)) == '0));

   assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (|dack) |-> (mem_rd ^ mem_wr));

   assert_idle_no_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (dack == '0) |-> (!mem_rd && !mem_wr));

   assert_tc_after_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tc |-> ($past(dack) != '0));

   assert_tc_masks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tc |-> ((mask_state & tc_status & $past(dack)) == $past(dack)));

   assert_tc_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tc |=> !tc);

endmodule

bind dma_xfer_engine dma_xfer_engine_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .dreq       (dreq),
   .dack       (dack),
   .mem_rd     (mem_rd),
   .mem_wr     (mem_wr),
   .tc         (tc),
   .mask_state (mask_state),
   .tc_status  (tc_status)
);

// File: tb/dma_xfer_engine_bench.sv
module dma_xfer_engine_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  dreq = '0;
   logic [3:0]  dack;
   logic [23:0] mem_addr;
   logic        mem_rd, mem_wr, tc;
   logic [3:0]  mask_state, tc_status;
   logic        page_we = 1'b0;
   logic [7:0]  page_port = '0;
   logic [7:0]  page_data = '0;
   logic        prog_we = 1'b0;
   logic [1:0]  prog_chan = '0;
   logic [15:0] prog_addr = '0;
   logic [15:0] prog_count = '0;
   logic        prog_dir = 1'b0;
   logic        mask_we = 1'b0;
   logic [1:0]  mask_chan = '0;
   logic        mask_set = 1'b0;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   dma_xfer_engine u_dma_xfer_engine (
      .clk(clk), .rst_n(rst_n), .dreq(dreq), .dack(dack), .mem_addr(mem_addr),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .tc(tc), .mask_state(mask_state),
      .tc_status(tc_status), .page_we(page_we), .page_port(page_port),
      .page_data(page_data), .prog_we(prog_we), .prog_chan(prog_chan),
      .prog_addr(prog_addr), .prog_count(prog_count), .prog_dir(prog_dir),
      .mask_we(mask_we), .mask_chan(mask_chan), .mask_set(mask_set)
   );

   // {chan[1:0], dir, page[7:0], addr[15:0], count[15:0]}
   localparam logic [42:0] VECS [6] = '{
      {2'd0, 1'b1, 8'h12, 16'h0100, 16'd3},
      {2'd1, 1'b0, 8'h34, 16'hFFFE, 16'd3},
      {2'd2, 1'b1, 8'h00, 16'h0000, 16'd0},
      {2'd3, 1'b0, 8'hFF, 16'h8000, 16'd2},
      {2'd0, 1'b0, 8'h56, 16'hFFFF, 16'd1},
      {2'd2, 1'b0, 8'hA5, 16'h1234, 16'd5}
   };

   function automatic logic [7:0] port_of(input int ch);
      case (ch)
         0: port_of = 8'h87;
         1: port_of = 8'h83;
         2: port_of = 8'h81;
         default: port_of = 8'h82;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic write_page(input logic [7:0] port, input logic [7:0] val);
      @(negedge clk);
      page_we = 1'b1; page_port = port; page_data = val;
      @(negedge clk);
      page_we = 1'b0;
   endtask

   task automatic prog_ch(input int ch, input bit dir, input logic [15:0] addr,
                          input logic [15:0] cnt);
      @(negedge clk);
      prog_we = 1'b1; prog_chan = 2'(ch); prog_dir = dir;
      prog_addr = addr; prog_count = cnt;
      @(negedge clk);
      prog_we = 1'b0;
   endtask

   task automatic set_mask(input int ch, input bit val);
      @(negedge clk);
      mask_we = 1'b1; mask_chan = 2'(ch); mask_set = val;
      @(negedge clk);
      mask_we = 1'b0;
   endtask

   // Holds the request of one unmasked channel and checks every grant.
   task automatic run_ch(input int ch, input bit dir, input logic [7:0] page,
                         input logic [15:0] addr, input logic [15:0] cnt);
      int beats = 0;
      int tcs = 0;
      logic [3:0] prev = '0;
      logic [15:0] a;
      dreq[ch] = 1'b1;
      repeat (2 * (int'(cnt) + 1) + 6) begin
         @(negedge clk);
         if (dack != '0) begin
            a = addr + 16'(beats);
            chk(dack == 4'(1 << ch), "R4 grant channel", dack, 4'(1 << ch));
            chk(prev == '0, "R4 gap between grants", prev, 0);
            chk(mem_addr == {page, a}, "R2/R6 address", mem_addr, {page, a});
            chk(mem_rd == dir && mem_wr == !dir, "R5 strobe",
                {mem_rd, mem_wr}, {dir, !dir});
            beats++;
         end
         if (tc) begin
            chk(prev == 4'(1 << ch) && beats == int'(cnt) + 1,
                "R8 tc timing", beats, int'(cnt) + 1);
            tcs++;
         end
         prev = dack;
      end
      dreq[ch] = 1'b0;
      chk(beats == int'(cnt) + 1, "R7 transfer count", beats, int'(cnt) + 1);
      chk(tcs == 1, "R8 tc pulses", tcs, 1);
      chk(mask_state[ch] == 1'b1, "R8 mask after tc", mask_state, 4'(1 << ch));
      chk(tc_status[ch] == 1'b1, "R8 status after tc", tc_status, 4'(1 << ch));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not finish");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [3:0] order [2];
      int ng;
      int seen;

      repeat (3) @(negedge clk);
      // R1: state under reset
      chk(dack == '0 && !tc && !mem_rd && !mem_wr, "R1 outputs in reset",
          {dack, tc, mem_rd, mem_wr}, 0);
      chk(mask_state == 4'hF, "R1 mask in reset", mask_state, 4'hF);
      chk(tc_status == '0, "R1 status in reset", tc_status, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(mask_state == 4'hF && tc_status == '0 && dack == '0,
          "R1 after reset", {mask_state, tc_status, dack}, 12'hF00);

      // Stimulus table: R2 R5 R6 R7 R8
      for (int v = 0; v < 6; v++) begin
         write_page(port_of(int'(VECS[v][42:41])), VECS[v][39:32]);
         prog_ch(int'(VECS[v][42:41]), VECS[v][40], VECS[v][31:16], VECS[v][15:0]);
         set_mask(int'(VECS[v][42:41]), 1'b0);
         run_ch(int'(VECS[v][42:41]), VECS[v][40], VECS[v][39:32],
                VECS[v][31:16], VECS[v][15:0]);
      end

      // R10: programming clears status, leaves mask set
      prog_ch(3, 1'b1, 16'h0040, 16'd0);
      @(negedge clk);
      chk(tc_status[3] == 1'b0, "R10 status cleared", tc_status, 4'h0);
      chk(mask_state[3] == 1'b1, "R10 mask kept", mask_state, 4'h8);

      // R3: masked channel ignores its request
      dreq[3] = 1'b1;
      seen = 0;
      repeat (10) begin
         @(negedge clk);
         if (dack != '0) seen++;
      end
      dreq[3] = 1'b0;
      chk(seen == 0, "R3 masked request ignored", seen, 0);

      // R9: ch1 and ch2 contend, ch1 first
      write_page(8'h83, 8'h00);
      write_page(8'h81, 8'h00);
      prog_ch(1, 1'b1, 16'h0010, 16'd0);
      prog_ch(2, 1'b0, 16'h0020, 16'd0);
      set_mask(1, 1'b0);
      set_mask(2, 1'b0);
      dreq = 4'b0110;
      ng = 0;
      repeat (10) begin
         @(negedge clk);
         if (dack != '0 && ng < 2) begin
            order[ng] = dack;
            ng++;
         end
      end
      dreq = '0;
      chk(ng == 2, "R9 grants seen", ng, 2);
      chk(order[0] == 4'b0010, "R9 first grant", order[0], 4'b0010);
      chk(order[1] == 4'b0100, "R9 second grant", order[1], 4'b0100);

      // R2: writes to undecoded ports change no page
      write_page(8'h87, 8'h21);
      write_page(8'h80, 8'h99);
      write_page(8'h88, 8'h99);
      write_page(8'h84, 8'h99);
      prog_ch(0, 1'b1, 16'h0005, 16'd0);
      set_mask(0, 1'b0);
      run_ch(0, 1'b1, 8'h21, 16'h0005, 16'd0);

      // R10: explicit mask set blocks a programmed channel
      prog_ch(1, 1'b0, 16'h0001, 16'd4);
      set_mask(1, 1'b0);
      set_mask(1, 1'b1);
      dreq[1] = 1'b1;
      seen = 0;
      repeat (8) begin
         @(negedge clk);
         if (dack != '0) seen++;
      end
      dreq[1] = 1'b0;
      chk(seen == 0 && mask_state[1], "R10 mask write", seen, 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule